// File: doc/BRIEF.md
# Supply Loss Access Guard

This block stands between an external byte-wide bus and a battery-backed RAM with its clock registers. Two digital comparator outputs tell it whether the main supply is above the write-protect level and above the battery-switch level, and a third says whether the backup cell is worn out. All three are asynchronous levels, so the block passes them through a two-flop synchronizer before use.

While the supply is too low, the block holds the gated chip-enable, output-enable and write strobes inactive and keeps the data drivers off. It drives an active-low reset that goes low on a supply loss. When the supply comes back, the reset stays low for a fixed recovery time, set as a parameter from the clock rate (35 ms at the default), before access opens again. A write strobe that is live when the loss is seen is cut off at once. It stays cut until the raw strobe is released, so a write held across the outage can never land after recovery.

The block also picks between main and backup supply, with a parameter for the low-voltage variant. It keeps a one-time latch that connects the backup cell on the first good supply, and it reports whether the cell is still healthy.

Top module: `pwrfail_guard`

## Requirements
- R1: While the synchronized write-protect comparator is low, `ce_n_o`, `oe_n_o` and `we_n_o` are 1 and `dq_oe_o` is 0, whatever the raw strobes do.
- R2: A fall of `vcc_above_pf_i` driven before clock edge 1 blocks access from edge 2 on and drives `reset_n_o` to 0 from edge 3 on.
- R3: After `vcc_above_pf_i` rises before edge 1 and stays high, `reset_n_o` is 0 through edge 2+REC_CYCLES and 1 from edge 3+REC_CYCLES on. REC_CYCLES = CLK_HZ/1000*REC_MS.
- R4: A supply dip during the recovery count aborts it, and a later recovery restarts the full count.
- R5: With LOW_VCC=0, `on_battery_o` is 1 exactly when the synchronized battery-switch comparator is low and the backup cell is connected.
- R6: With LOW_VCC=1, `on_battery_o` is 1 only when both synchronized comparators are low and the backup cell is connected.
- R7: `batt_link_o` is 0 out of `rst_n`, goes to 1 on the first synchronized high of the write-protect comparator, and then stays 1 through later supply losses. `on_battery_o` is never 1 while it is 0.
- R8: `batt_good_o` is the inverse of `batt_low_i` two clock edges later (1 = good cell, 0 = exhausted).
- R9: Once a write is attempted while access is blocked, `we_n_o` stays 1 until `we_n_i` has been seen high at a clock edge, even after access reopens.
- R10: While access is open, `ce_n_o` and `oe_n_o` follow the raw strobes combinationally. `we_n_o` does too, unless R9 blocks it. `dq_oe_o` is 1 exactly when `ce_n_i`=0, `oe_n_i`=0 and `we_n_i`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| vcc_above_pf_i | input | 1 | Comparator: supply above write-protect level (async) |
| vcc_above_so_i | input | 1 | Comparator: supply above battery-switch level (async) |
| batt_low_i | input | 1 | Backup cell exhausted indicator (async) |
| ce_n_i | input | 1 | Raw chip enable, active low |
| oe_n_i | input | 1 | Raw output enable, active low |
| we_n_i | input | 1 | Raw write enable, active low |
| ce_n_o | output | 1 | Gated chip enable, active low |
| oe_n_o | output | 1 | Gated output enable, active low |
| we_n_o | output | 1 | Gated write enable, active low |
| dq_oe_o | output | 1 | Data output driver enable |
| reset_n_o | output | 1 | Supply-fail reset, active low, stretched on recovery |
| on_battery_o | output | 1 | 1 selects backup supply |
| batt_link_o | output | 1 | Backup cell connected (one-time latch) |
| batt_good_o | output | 1 | Backup cell health flag, 1 = good |

## Verification
The assertions assume that the comparator inputs are slow levels that move seldom compared with the clock. They also assume that `rst_n` is asserted only as a power-on event, so the battery latch starts cleared. The stimulus holds every comparator level for at least three clock edges, and it changes raw strobes only at falling clock edges, so that each sampled cycle has one defined input set. The random phases draw strobe patterns and comparator levels from a fixed seed, and each expected value is taken once the two synchronizer stages have settled.

// File: rtl/pfg_pkg.sv
package pfg_pkg;
    typedef enum logic [1:0] {
        PF_FAIL    = 2'd0,
        PF_RECOVER = 2'd1,
        PF_RUN     = 2'd2
    } pf_state_e;

    localparam int unsigned SYN_PF = 0;
    localparam int unsigned SYN_SO = 1;
    localparam int unsigned SYN_BL = 2;
    localparam int unsigned SYN_W  = 3;
endpackage

// File: rtl/pfg_sync.sv
module pfg_sync #(
    parameter int unsigned W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } syn_t;

    syn_t d, q;

    always_comb begin
        d    = q;
        d.s1 = async_i;
        d.s2 = q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sync_o = q.s2;
endmodule

// File: rtl/pfg_recovery.sv
module pfg_recovery
    import pfg_pkg::*;
#(
    parameter int unsigned LIMIT = 35
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pf_ok_i,
    output logic run_o
);
    localparam int unsigned CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    typedef struct packed {
        pf_state_e     st;
        logic [CW-1:0] cnt;
    } rec_t;

    rec_t d, q;

    always_comb begin
        d = q;
        case (q.st)
            PF_FAIL: begin
                if (pf_ok_i) begin
                    d.st  = PF_RECOVER;
                    d.cnt = '0;
                end
            end
            PF_RECOVER: begin
                if (!pf_ok_i) begin
                    d.st  = PF_FAIL;
                    d.cnt = '0;
                end else if (q.cnt == LAST) begin
                    d.st = PF_RUN;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            PF_RUN: begin
                if (!pf_ok_i) d.st = PF_FAIL;
            end
            default: d.st = PF_FAIL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: PF_FAIL, cnt: '0};
        else        q <= d;
    end

    assign run_o = (q.st == PF_RUN);

    p_fail_on_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pf_ok_i) |=> (q.st == PF_FAIL));

    p_release_after_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_o) |-> ($past(q.st) == PF_RECOVER && $past(q.cnt) == LAST));

    p_dip_aborts_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == PF_RECOVER && !pf_ok_i) |=> !run_o);
endmodule

// File: rtl/pfg_supply.sv
module pfg_supply #(
    parameter bit LOW_VCC = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pf_ok_i,
    input  logic so_ok_i,
    output logic link_o,
    output logic on_batt_o
);
    typedef struct packed {
        logic link;
    } sup_t;

    sup_t d, q;
    logic below_w;

    generate
        if (LOW_VCC) begin : g_lowv
            assign below_w = !so_ok_i && !pf_ok_i;
        end else begin : g_std
            assign below_w = !so_ok_i;
        end
    endgenerate

    always_comb begin
        d = q;
        if (pf_ok_i) d.link = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign link_o    = q.link;
    assign on_batt_o = q.link && below_w;

    p_link_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        link_o |=> link_o);

    p_link_on_good_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pf_ok_i |=> link_o);

    p_batt_needs_low_so_r5: assert property (@(posedge clk) disable iff (!rst_n)
        on_batt_o |-> !so_ok_i);

    generate
        if (LOW_VCC) begin : g_lowv_chk
            p_lowv_both_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
                on_batt_o |-> !pf_ok_i);
        end
    endgenerate
endmodule

// File: rtl/pwrfail_guard.sv
module pwrfail_guard
    import pfg_pkg::*;
#(
    parameter int unsigned CLK_HZ  = 125_000_000,
    parameter int unsigned REC_MS  = 35,
    parameter bit          LOW_VCC = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vcc_above_pf_i,
    input  logic vcc_above_so_i,
    input  logic batt_low_i,
    input  logic ce_n_i,
    input  logic oe_n_i,
    input  logic we_n_i,
    output logic ce_n_o,
    output logic oe_n_o,
    output logic we_n_o,
    output logic dq_oe_o,
    output logic reset_n_o,
    output logic on_battery_o,
    output logic batt_link_o,
    output logic batt_good_o
);
    localparam int unsigned REC_CYCLES = (CLK_HZ / 1000) * REC_MS;

    typedef struct packed {
        logic wblk;
    } top_t;

    logic [SYN_W-1:0] raw_w, syn_w;
    logic             run_w;
    logic             access_ok;
    top_t             d, q;

    assign raw_w[SYN_PF] = vcc_above_pf_i;
    assign raw_w[SYN_SO] = vcc_above_so_i;
    assign raw_w[SYN_BL] = batt_low_i;

    pfg_sync #(.W(SYN_W)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_w),
        .sync_o  (syn_w)
    );

    pfg_recovery #(.LIMIT(REC_CYCLES)) u_rec (
        .clk     (clk),
        .rst_n   (rst_n),
        .pf_ok_i (syn_w[SYN_PF]),
        .run_o   (run_w)
    );

    pfg_supply #(.LOW_VCC(LOW_VCC)) u_sup (
        .clk       (clk),
        .rst_n     (rst_n),
        .pf_ok_i   (syn_w[SYN_PF]),
        .so_ok_i   (syn_w[SYN_SO]),
        .link_o    (batt_link_o),
        .on_batt_o (on_battery_o)
    );

    assign access_ok = run_w && syn_w[SYN_PF];

    always_comb begin
        d = q;
        if (we_n_i)          d.wblk = 1'b0;
        else if (!access_ok) d.wblk = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ce_n_o      = ce_n_i || !access_ok;
    assign oe_n_o      = oe_n_i || !access_ok;
    assign we_n_o      = we_n_i || !access_ok || q.wblk;
    assign dq_oe_o     = access_ok && !ce_n_i && !oe_n_i && we_n_i;
    assign reset_n_o   = run_w;
    assign batt_good_o = !syn_w[SYN_BL];

    p_blocked_in_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !reset_n_o |-> (ce_n_o && oe_n_o && we_n_o && !dq_oe_o));

    p_write_stays_cut_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!access_ok && !we_n_i) && !we_n_i) |-> we_n_o);

    p_no_read_while_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n_i |-> !dq_oe_o);
endmodule

// File: tb/pwrfail_guard_tb.sv
module pwrfail_guard_tb;
    localparam int unsigned CLK_HZ = 2000;
    localparam int unsigned REC_MS = 35;
    localparam int unsigned REC    = (CLK_HZ / 1000) * REC_MS;

    logic clk = 1'b0;
    logic rst_n;
    logic pf, so, bl, ce_n, oe_n, we_n;
    logic ce_o, oe_o, we_o, dq_oe, rst_o, onb, link, good;
    logic ce_o2, oe_o2, we_o2, dq_oe2, rst_o2, onb2, link2, good2;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pwrfail_guard #(.CLK_HZ(CLK_HZ), .REC_MS(REC_MS), .LOW_VCC(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .vcc_above_pf_i(pf), .vcc_above_so_i(so),
        .batt_low_i(bl), .ce_n_i(ce_n), .oe_n_i(oe_n), .we_n_i(we_n),
        .ce_n_o(ce_o), .oe_n_o(oe_o), .we_n_o(we_o), .dq_oe_o(dq_oe),
        .reset_n_o(rst_o), .on_battery_o(onb), .batt_link_o(link), .batt_good_o(good));

    pwrfail_guard #(.CLK_HZ(CLK_HZ), .REC_MS(REC_MS), .LOW_VCC(1'b1)) u_dut_lv (
        .clk(clk), .rst_n(rst_n), .vcc_above_pf_i(pf), .vcc_above_so_i(so),
        .batt_low_i(bl), .ce_n_i(ce_n), .oe_n_i(oe_n), .we_n_i(we_n),
        .ce_n_o(ce_o2), .oe_n_o(oe_o2), .we_n_o(we_o2), .dq_oe_o(dq_oe2),
        .reset_n_o(rst_o2), .on_battery_o(onb2), .batt_link_o(link2), .batt_good_o(good2));

    function automatic bit exp_onb(bit lowv, bit p, bit s, bit lk);
        if (lowv) return lk && !s && !p;
        return lk && !s;
    endfunction

    function automatic bit exp_dq(bit c, bit o, bit w);
        return !c && !o && w;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic edges(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            finish_run();
        end
    end

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'h5EED_0042);
        rst_n = 1'b0; pf = 1'b0; so = 1'b0; bl = 1'b0;
        ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
        edges(3);
        // Reset state
        check("R7 link at reset", int'(link), 0);
        check("R7 no battery before link", int'(onb), 0);
        check("R2 reset low at start", int'(rst_o), 0);
        check("R8 flag at reset", int'(good), 1);
        check("R1 strobes gated at start", int'({ce_o, oe_o, we_o, dq_oe}), 4'b1110);
        rst_n = 1'b1;
        edges(2);
        check("R7 no battery before link", int'(onb), 0);
        check("R7 no battery before link lv", int'(onb2), 0);

        // R3 power-up recovery timing
        pf = 1'b1; so = 1'b1;
        edges(2 + REC);
        check("R3 reset held through count", int'(rst_o), 0);
        check("R7 link set after first good supply", int'(link), 1);
        edges(1);
        check("R3 reset released after count", int'(rst_o), 1);
        check("R3 lv instance released", int'(rst_o2), 1);

        // R10 pass-through with random strobes
        for (int i = 0; i < 40; i++) begin
            ce_n = 1'($urandom); oe_n = 1'($urandom); we_n = 1'($urandom);
            #1;
            check("R10 ce pass", int'(ce_o), int'(ce_n));
            check("R10 oe pass", int'(oe_o), int'(oe_n));
            check("R10 we pass", int'(we_o), int'(we_n));
            check("R10 dq enable", int'(dq_oe), int'(exp_dq(ce_n, oe_n, we_n)));
            edges(1);
        end

        // R2 / R9 write cut on supply loss
        ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b0;
        #1;
        check("R10 write open", int'(we_o), 0);
        @(negedge clk);
        pf = 1'b0;
        edges(1);
        check("R2 still open one edge after", int'(we_o), 0);
        edges(1);
        check("R2 write cut two edges after", int'(we_o), 1);
        check("R2 ce cut two edges after", int'(ce_o), 1);
        check("R2 reset not yet low", int'(rst_o), 1);
        edges(1);
        check("R2 reset low three edges after", int'(rst_o), 0);
        check("R7 link kept through loss", int'(link), 1);

        // R1 random strobes while blocked, write held low
        for (int i = 0; i < 20; i++) begin
            ce_n = 1'($urandom); oe_n = 1'($urandom);
            #1;
            check("R1 blocked strobes", int'({ce_o, oe_o, we_o, dq_oe}), 4'b1110);
            edges(1);
        end

        // R9 held write stays cut after recovery
        ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b0;
        pf = 1'b1;
        edges(3 + REC);
        check("R3 released again", int'(rst_o), 1);
        check("R9 held write still cut", int'(we_o), 1);
        check("R10 ce open after recovery", int'(ce_o), 0);
        we_n = 1'b1;
        edges(1);
        we_n = 1'b0;
        #1;
        check("R9 fresh write passes", int'(we_o), 0);
        @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1;

        // R4 dip during recovery restarts the count
        pf = 1'b0;
        edges(4);
        pf = 1'b1;
        edges(3 + REC / 2);
        pf = 1'b0;
        edges(3);
        check("R4 reset low after dip", int'(rst_o), 0);
        pf = 1'b1;
        edges(2 + REC);
        check("R4 full count restarted", int'(rst_o), 0);
        edges(1);
        check("R4 release after full count", int'(rst_o), 1);

        // R5 / R6 supply select
        so = 1'b0;
        edges(1);
        check("R5 select after sync only", int'(onb), 0);
        edges(1);
        check("R5 battery below switch level", int'(onb), 1);
        check("R6 lv stays on main", int'(onb2), 0);
        pf = 1'b0;
        edges(2);
        check("R6 lv battery below both", int'(onb2), 1);
        check("R5 std still battery", int'(onb), 1);
        so = 1'b1;
        edges(2);
        check("R5 main above switch level", int'(onb), 0);
        check("R6 lv main when switch level ok", int'(onb2), 0);
        check("R7 link kept lv", int'(link2), 1);

        // R8 battery flag
        bl = 1'b1;
        edges(1);
        check("R8 flag after sync only", int'(good), 1);
        edges(1);
        check("R8 flag exhausted", int'(good), 0);
        bl = 1'b0;
        edges(2);
        check("R8 flag good again", int'(good), 1);

        // Random comparator levels
        for (int i = 0; i < 30; i++) begin
            pf = 1'($urandom); so = 1'($urandom); bl = 1'($urandom);
            ce_n = 1'($urandom); oe_n = 1'($urandom); we_n = 1'b1;
            edges(3 + int'($urandom_range(0, 3)));
            check("R5 random select", int'(onb), int'(exp_onb(1'b0, pf, so, 1'b1)));
            check("R6 random select lv", int'(onb2), int'(exp_onb(1'b1, pf, so, 1'b1)));
            check("R8 random flag", int'(good), int'(!bl));
            if (!pf)
                check("R1 random blocked", int'({ce_o, oe_o, we_o, dq_oe}), 4'b1110);
        end

        done = 1'b1;
        finish_run();
    end
endmodule